// File: doc/BRIEF.md
# Byte-Serial Accumulator Processor

This block is a minimal 8-bit processor built around one accumulator and one helper register. It reads its program over a single-byte memory port, one byte per bus transaction. An opcode determines how many further bytes belong to the instruction: none, one immediate byte, or a two-byte address. The processor keeps those extra bytes in internal holding registers and executes the instruction only after its last byte has arrived.

Each read is split into two cycles. In the first cycle the block drives the address and a one-cycle read strobe. In the second cycle it captures the returned byte. The program counter advances once for every instruction byte fetched. A jump replaces the program counter in the execute cycle, so the next opcode read goes to the new target. The block implements only a fixed handful of opcodes. Every other code value runs as a one-byte no-operation. The accumulator, the helper register, the program counter and the two flags are brought out on debug ports so that a test environment can follow execution.

Top module: `acc8_core`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter, accumulator, helper register and both flags are cleared to zero. The first read after reset goes to address 0x0000.
- R2: Every byte read is a one-cycle `mem_rd` pulse, and `mem_rd` is never high in two consecutive cycles. The byte is captured in the cycle after the pulse. The program counter rises by one for each instruction byte fetched.
- R3: Opcodes 0x3E and 0x06 are two bytes long. Opcodes 0x3A and 0xC3 are three bytes long. All others are one byte. From one opcode read to the next takes 3 cycles for one-byte instructions, 5 for two-byte ones, 7 for 0xC3 and 9 for 0x3A.
- R4: In a three-byte instruction, the byte after the opcode is the low half of the 16-bit address and the byte after that is the high half.
- R5: Opcode 0x47 copies the accumulator into the helper register.
- R6: Opcode 0x80 adds the helper register to the accumulator modulo 256. Carry is set to bit 8 of the sum and zero is set when the 8-bit result is 0x00. `dbg_flags` bit 1 is carry and bit 0 is zero.
- R7: Opcode 0x2F inverts every accumulator bit and leaves both flags unchanged.
- R8: Opcode 0x3E loads its immediate byte into the accumulator and opcode 0x06 loads it into the helper register. Neither changes the flags.
- R9: Opcode 0x3A issues exactly one extra read at the assembled address and loads that byte into the accumulator.
- R10: Opcode 0xC3 sets the program counter to the assembled address. The next opcode read goes to that address, and the bytes that follow the jump in memory are never executed.
- R11: Any opcode not listed above changes no register or flag, and the next opcode read is at the following address.
- R12: `mem_wr` is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Address of the current read |
| mem_rd | output | 1 | Read strobe, one cycle per byte |
| mem_wr | output | 1 | Write strobe, held low in this subset |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| dbg_acc | output | 8 | Accumulator |
| dbg_b | output | 8 | Helper register |
| dbg_pc | output | 16 | Program counter |
| dbg_flags | output | 2 | {carry, zero} |

## Verification
The hardest case to reach from the ports is an address whose two halves are put together in the wrong order. Such a fault still produces a plausible read, just from another location. The program therefore loads from 0x0120 and stores a different, recognisable byte at the swapped address 0x2001. Reads to both addresses are counted. A jump is placed directly in front of a byte pair that would clear the accumulator if it were executed, which exposes any stale fetch. The flag behaviour is also covered: the add is run once with a zero-and-carry result, once with carry only and once with neither flag, and an invert follows in each flag state so that any change it makes to the flags shows up.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;

  localparam logic [DW-1:0] OP_MOVBA = 8'h47;
  localparam logic [DW-1:0] OP_ADDB  = 8'h80;
  localparam logic [DW-1:0] OP_INV   = 8'h2F;
  localparam logic [DW-1:0] OP_LDIA  = 8'h3E;
  localparam logic [DW-1:0] OP_LDIB  = 8'h06;
  localparam logic [DW-1:0] OP_LDM   = 8'h3A;
  localparam logic [DW-1:0] OP_JUMP  = 8'hC3;

  typedef enum logic [2:0] {
    ST_OPC = 3'd0,
    ST_IMM = 3'd1,
    ST_ADH = 3'd2,
    ST_MRD = 3'd3,
    ST_EXE = 3'd4
  } phase_t;

  function automatic logic [DW:0] add_wide(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [1:0] op_bytes(input logic [DW-1:0] op);
    case (op)
      OP_LDIA, OP_LDIB: return 2'd2;
      OP_LDM, OP_JUMP:  return 2'd3;
      default:          return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/acc8_lenmap.sv
module acc8_lenmap
  import acc8_pkg::*;
(
  input  logic [DW-1:0] opcode,
  output logic [1:0]    nbytes
);
  assign nbytes = op_bytes(opcode);
endmodule

// File: rtl/acc8_exec.sv
module acc8_exec
  import acc8_pkg::*;
(
  input  logic [DW-1:0] opcode,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] imm_i,
  input  logic [DW-1:0] mem_i,
  input  logic          cy_i,
  input  logic          zr_i,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] b_o,
  output logic          cy_o,
  output logic          zr_o
);
  logic [DW:0] sum;
  assign sum = add_wide(acc_i, b_i);

  always_comb begin
    acc_o = acc_i;
    b_o   = b_i;
    cy_o  = cy_i;
    zr_o  = zr_i;
    case (opcode)
      OP_MOVBA: b_o = acc_i;
      OP_ADDB: begin
        acc_o = sum[DW-1:0];
        cy_o  = sum[DW];
        zr_o  = (sum[DW-1:0] == '0);
      end
      OP_INV:  acc_o = ~acc_i;
      OP_LDIA: acc_o = imm_i;
      OP_LDIB: b_o   = imm_i;
      OP_LDM:  acc_o = mem_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] dbg_acc,
  output logic [DW-1:0] dbg_b,
  output logic [AW-1:0] dbg_pc,
  output logic [1:0]    dbg_flags
);
  phase_t        state;
  logic          half_q;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] opc_q, lo_q, hi_q, md_q, acc_q, b_q;
  logic          cy_q, zr_q;
  logic [1:0]    new_len, cur_len;
  logic [DW-1:0] x_acc, x_b;
  logic          x_cy, x_zr;

  // named events used by the assertions
  logic byte_req, exec_fire, exec_jmp, exec_add, exec_inv;
  assign mem_rd    = (state != ST_EXE) && !half_q;
  assign byte_req  = mem_rd && (state != ST_MRD);
  assign exec_fire = (state == ST_EXE);
  assign exec_jmp  = exec_fire && (opc_q == OP_JUMP);
  assign exec_add  = exec_fire && (opc_q == OP_ADDB);
  assign exec_inv  = exec_fire && (opc_q == OP_INV);

  assign mem_addr  = (state == ST_MRD) ? {hi_q, lo_q} : pc_q;
  assign mem_wr    = 1'b0;
  assign dbg_acc   = acc_q;
  assign dbg_b     = b_q;
  assign dbg_pc    = pc_q;
  assign dbg_flags = {cy_q, zr_q};

  acc8_lenmap u_len_new (.opcode(mem_rdata), .nbytes(new_len));
  acc8_lenmap u_len_cur (.opcode(opc_q),     .nbytes(cur_len));

  acc8_exec u_exec (
    .opcode(opc_q), .acc_i(acc_q), .b_i(b_q), .imm_i(lo_q), .mem_i(md_q),
    .cy_i(cy_q), .zr_i(zr_q), .acc_o(x_acc), .b_o(x_b), .cy_o(x_cy), .zr_o(x_zr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_OPC;
      half_q <= 1'b0;
      pc_q   <= '0;
      opc_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      md_q   <= '0;
      acc_q  <= '0;
      b_q    <= '0;
      cy_q   <= 1'b0;
      zr_q   <= 1'b0;
    end else begin
      if (byte_req) pc_q <= pc_q + 1'b1;
      if (mem_rd) half_q <= 1'b1;
      case (state)
        ST_OPC: if (half_q) begin
          half_q <= 1'b0;
          opc_q  <= mem_rdata;
          state  <= (new_len == 2'd1) ? ST_EXE : ST_IMM;
        end
        ST_IMM: if (half_q) begin
          half_q <= 1'b0;
          lo_q   <= mem_rdata;
          state  <= (cur_len == 2'd3) ? ST_ADH : ST_EXE;
        end
        ST_ADH: if (half_q) begin
          half_q <= 1'b0;
          hi_q   <= mem_rdata;
          state  <= (opc_q == OP_LDM) ? ST_MRD : ST_EXE;
        end
        ST_MRD: if (half_q) begin
          half_q <= 1'b0;
          md_q   <= mem_rdata;
          state  <= ST_EXE;
        end
        ST_EXE: begin
          acc_q <= x_acc;
          b_q   <= x_b;
          cy_q  <= x_cy;
          zr_q  <= x_zr;
          if (exec_jmp) pc_q <= {hi_q, lo_q};
          state <= ST_OPC;
        end
        default: state <= ST_OPC;
      endcase
    end
  end

  p_rd_gap_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    byte_req |=> (pc_q == $past(pc_q) + 1'b1));
  p_len3_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADH) |-> (cur_len == 2'd3));
  p_add_r6: assert property (@(posedge clk) disable iff (rst)
    exec_add |=> ({cy_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(b_q)})));
  p_zero_r6: assert property (@(posedge clk) disable iff (rst)
    exec_add |=> (zr_q == (acc_q == '0)));
  p_inv_r7: assert property (@(posedge clk) disable iff (rst)
    exec_inv |=> (cy_q == $past(cy_q) && zr_q == $past(zr_q) && acc_q == ~$past(acc_q)));
  p_jump_r10: assert property (@(posedge clk) disable iff (rst)
    exec_jmp |=> (pc_q == $past({hi_q, lo_q}) && state == ST_OPC));
endmodule

// File: tb/tb_acc8_core.sv
module tb_acc8_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  dbg_acc, dbg_b;
  logic [15:0] dbg_pc;
  logic [1:0]  dbg_flags;

  int checks = 0;
  int errors = 0;
  int wr_hits = 0, rd_pairs = 0, hits_0120 = 0, hits_2001 = 0;
  logic prev_rd = 1'b0;

  always #2.5 clk = ~clk;

  acc8_core dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_rdata(mem_rdata), .dbg_acc(dbg_acc), .dbg_b(dbg_b), .dbg_pc(dbg_pc),
    .dbg_flags(dbg_flags)
  );

  function automatic logic [7:0] mem_at(input logic [15:0] a);
    case (a)
      16'h0000: return 8'h3E;  16'h0001: return 8'h7F;
      16'h0002: return 8'h06;  16'h0003: return 8'h81;
      16'h0004: return 8'h80;  16'h0005: return 8'h2F;
      16'h0006: return 8'h47;  16'h0007: return 8'h3E;
      16'h0008: return 8'h10;  16'h0009: return 8'h80;
      16'h000A: return 8'h47;  16'h000B: return 8'h80;
      16'h000C: return 8'h3A;  16'h000D: return 8'h20;
      16'h000E: return 8'h01;  16'h000F: return 8'hFF;
      16'h0010: return 8'hC3;  16'h0011: return 8'h00;
      16'h0012: return 8'h02;  16'h0013: return 8'h3E;
      16'h0014: return 8'h00;  16'h0120: return 8'hA5;
      16'h2001: return 8'h5A;  16'h0200: return 8'h2F;
      16'h0201: return 8'hC3;  16'h0202: return 8'h01;
      16'h0203: return 8'h02;
      default:  return 8'h00;
    endcase
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_at(mem_addr);

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_wr) wr_hits++;
      if (mem_rd && prev_rd) rd_pairs++;
      if (mem_rd && mem_addr == 16'h0120) hits_0120++;
      if (mem_rd && mem_addr == 16'h2001) hits_2001++;
    end
    prev_rd = mem_rd && !rst;
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_str(input logic [3:0] t);
    case (t)
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      4'd11: return "R11";
      default: return "R?";
    endcase
  endfunction

  typedef struct packed {
    logic [15:0] nxt;
    logic [7:0]  acc;
    logic [7:0]  b;
    logic [1:0]  fl;
    logic [3:0]  cyc;
    logic [3:0]  tag;
  } vec_t;

  // each row: next opcode address, expected A, B, {carry,zero}, cycles, requirement
  localparam vec_t VEC [14] = '{
    '{16'h0002, 8'h7F, 8'h00, 2'b00, 4'd5, 4'd8},   // R8 immediate to A
    '{16'h0004, 8'h7F, 8'h81, 2'b00, 4'd5, 4'd8},   // R8 immediate to B
    '{16'h0005, 8'h00, 8'h81, 2'b11, 4'd3, 4'd6},   // R6 wrap to zero, carry
    '{16'h0006, 8'hFF, 8'h81, 2'b11, 4'd3, 4'd7},   // R7 flags kept
    '{16'h0007, 8'hFF, 8'hFF, 2'b11, 4'd3, 4'd5},   // R5 copy
    '{16'h0009, 8'h10, 8'hFF, 2'b11, 4'd5, 4'd8},   // R8 flags kept
    '{16'h000A, 8'h0F, 8'hFF, 2'b10, 4'd3, 4'd6},   // R6 carry only
    '{16'h000B, 8'h0F, 8'h0F, 2'b10, 4'd3, 4'd5},   // R5
    '{16'h000C, 8'h1E, 8'h0F, 2'b00, 4'd3, 4'd6},   // R6 no flags
    '{16'h000F, 8'hA5, 8'h0F, 2'b00, 4'd9, 4'd9},   // R9 / R4 memory load
    '{16'h0010, 8'hA5, 8'h0F, 2'b00, 4'd3, 4'd11},  // R11 unknown opcode
    '{16'h0200, 8'hA5, 8'h0F, 2'b00, 4'd7, 4'd10},  // R10 jump, stale bytes skipped
    '{16'h0201, 8'h5A, 8'h0F, 2'b00, 4'd3, 4'd7},   // R7 invert, no flags
    '{16'h0201, 8'h5A, 8'h0F, 2'b00, 4'd7, 4'd10}   // R10 self jump
  };

  task automatic wait_fetch(input logic [15:0] target, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(mem_rd && mem_addr == target) && n < 40);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk("R1", "pc",    dbg_pc, 16'h0000);
    chk("R1", "acc",   dbg_acc, 8'h00);
    chk("R1", "b",     dbg_b, 8'h00);
    chk("R1", "flags", dbg_flags, 2'b00);
    chk("R1", "first read", {15'd0, mem_rd, mem_addr}, {15'd0, 1'b1, 16'h0000});
    rst = 1'b0;

    for (int i = 0; i < 14; i++) begin
      wait_fetch(VEC[i].nxt, n);
      chk(tag_str(VEC[i].tag), "next fetch addr", {15'd0, mem_rd, mem_addr}, {15'd0, 1'b1, VEC[i].nxt});
      chk("R2", "pc at fetch", dbg_pc, VEC[i].nxt);
      chk("R3", "cycles", n, VEC[i].cyc);
      chk(tag_str(VEC[i].tag), "acc", dbg_acc, VEC[i].acc);
      chk(tag_str(VEC[i].tag), "b", dbg_b, VEC[i].b);
      chk(tag_str(VEC[i].tag), "flags", dbg_flags, VEC[i].fl);
    end

    chk("R4", "reads at 0x0120", hits_0120, 1);
    chk("R4", "reads at swapped 0x2001", hits_2001, 0);
    chk("R9", "single data read", hits_0120, 1);
    chk("R2", "back-to-back strobes", rd_pairs, 0);
    chk("R12", "write strobes", wr_hits, 0);

    // R1: reset mid-run clears everything and restarts at 0x0000
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "pc after reset",    dbg_pc, 16'h0000);
    chk("R1", "acc after reset",   dbg_acc, 8'h00);
    chk("R1", "b after reset",     dbg_b, 8'h00);
    chk("R1", "flags after reset", dbg_flags, 2'b00);
    chk("R1", "restart read", {15'd0, mem_rd, mem_addr}, {15'd0, 1'b1, 16'h0000});
    rst = 1'b0;
    wait_fetch(16'h0002, n);
    chk("R1", "restart cycles", n, 5);
    chk("R8", "restart acc", dbg_acc, 8'h7F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule